// File: doc/BRIEF.md
# Incremental ADC Decimator with Adaptive Bias Control

This block is the digital back end of a column-parallel, second-order incremental delta-sigma converter. It receives one modulator decision per clock, and that decision counts as +1 or -1. A start pulse clears its cascade of two integrators. The block then accumulates exactly OSR decisions and publishes a 12-bit code with a one-cycle valid strobe.

While a conversion runs, the block keeps a 4-bit offset-binary estimate of the input, computed from the running sum of decisions. Each cycle it combines that estimate with the present modulator decision to set four unit-current enables for the first integrator's amplifier. The setting is registered, so it is stable before the integration phase it serves. The bias then follows the expected integration error. An enable input can force the amplifier to full bias.

Top module: `iadc_decimator`

## Requirements
- R1: After reset, busy_o and result_vld_o are 0, result_o is 0 and bias_en_o is 4'b1111.
- R2: A start_i pulse seen on a clock edge while idle begins a conversion. busy_o is high for exactly 100 cycles, and one modulator bit is sampled on each of the 100 following edges. A start_i seen in the cycle where result_vld_o is high is accepted.
- R3: start_i while busy_o is high is ignored: the conversion keeps its length and its result.
- R4: With S1 the running sum of decisions (bit 1 = +1, bit 0 = -1) and S2 the running sum of S1 after each sample, the result is clamp(2048 + trunc(S2*2048/5050), 0, 4095), where trunc rounds toward zero. It is output on the edge of the 100th sample.
- R5: result_vld_o is a single-cycle pulse, high in the cycle after the final sample edge. result_o holds its value until the next completion.
- R6: The estimate is 4'b1000 before the first sample. After k samples it is clamp(8 + trunc(8*S1/k), 0, 15), with 0000 meaning full-scale negative and 1111 full-scale positive.
- R7: On each sampling edge with adapt_en_i high, bias_en_o becomes the bitwise inverse of the current estimate if the sampled bit is 1, and the estimate unchanged if it is 0. At mid-scale both bit values give 1000/0111. At the 1111 end, a 1 bit gives 0000 and a 0 bit gives 1111.
- R8: On a sampling edge with adapt_en_i low, bias_en_o becomes 4'b1111.
- R9: On any edge while idle, bias_en_o becomes 4'b1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a conversion (honoured when idle) |
| mod_bit_i | input | 1 | Modulator decision, 1 = +1, 0 = -1 |
| adapt_en_i | input | 1 | 1 = adaptive bias, 0 = full bias |
| bias_en_o | output | 4 | Unit-current-source enables for the first amplifier |
| busy_o | output | 1 | Conversion in progress |
| result_o | output | 12 | Last conversion code |
| result_vld_o | output | 1 | One-cycle strobe when result_o updates |

## Verification
The bench sweeps every decision density from all-zeros to all-ones in sixteenths, plus a pseudo-random stream. This covers both clamp limits of the result: an all-ones stream lands exactly on 4096 and must clamp to 4095. Truncation toward zero on negative sums is also exercised, and a design that floors instead would be off by one code. The bias word is checked after every sample against an estimate the bench tracks. A design that used the estimate after the current sample, rather than before it, would show mismatches where the estimate changes. The bench also flips adapt_en_i inside a conversion and pulses start_i in mid-conversion and in the valid cycle. A design that restarted on the stray start would give a wrong result, and one that missed the back-to-back start would stall.

// File: rtl/iadc_pkg.sv
package iadc_pkg;

  typedef struct packed {
    logic busy;
    logic first;
    logic last;
  } seq_t;

  // Number of paths through a cascade of 'order' integrators over 'osr' steps:
  // the peak magnitude of the last integrator for a constant full-scale stream.
  function automatic int full_scale(input int osr, input int order);
    int fs;
    fs = 1;
    for (int k = 1; k <= order; k++) fs = fs * (osr + k - 1) / k;
    return fs;
  endfunction

  // Map acc in [-span, span] onto an offset-binary code of out_w bits,
  // truncating toward zero and clamping at both ends.
  function automatic int scale_clamp(input int acc, input int span, input int out_w);
    int mid;
    int v;
    mid = 1 << (out_w - 1);
    if (span <= 0) return mid;
    v = mid + (acc * mid) / span;
    if (v < 0) v = 0;
    else if (v > 2 * mid - 1) v = 2 * mid - 1;
    return v;
  endfunction

endpackage

// File: rtl/iadc_seq_ctrl.sv
module iadc_seq_ctrl
  import iadc_pkg::*;
#(
  parameter int OSR   = 100,
  parameter int CNT_W = $clog2(OSR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             accept_o,
  output seq_t             st_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(OSR - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  assign accept_o    = start_i && !busy_q;
  assign st_o.busy   = busy_q;
  assign st_o.first  = busy_q && (cnt_q == '0);
  assign st_o.last   = busy_q && (cnt_q == LAST_IDX);
  assign cnt_o       = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST_IDX) busy_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/iadc_integrator.sv
module iadc_integrator #(
  parameter int W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                en_i,
  input  logic signed [W-1:0] in_i,
  output logic signed [W-1:0] sum_o
);
  logic signed [W-1:0] acc_q;

  assign sum_o = acc_q + in_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (en_i)  acc_q <= sum_o;
  end
endmodule

// File: rtl/iadc_bias_ctrl.sv
module iadc_bias_ctrl #(
  parameter int EST_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             mod_bit_i,
  input  logic             adapt_en_i,
  input  logic [EST_W-1:0] est_next_i,
  output logic [EST_W-1:0] bias_o
);
  localparam logic [EST_W-1:0] MID = EST_W'(1) << (EST_W - 1);

  logic [EST_W-1:0] est_q;
  logic [EST_W-1:0] bias_d;

  // Bias for the coming integration uses the estimate from earlier samples.
  always_comb begin
    if (!step_i || !adapt_en_i) bias_d = '1;
    else if (mod_bit_i)         bias_d = ~est_q;
    else                        bias_d = est_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      est_q  <= MID;
      bias_o <= '1;
    end else begin
      bias_o <= bias_d;
      if (clr_i)       est_q <= MID;
      else if (step_i) est_q <= est_next_i;
    end
  end
endmodule

// File: rtl/iadc_decimator.sv
module iadc_decimator
  import iadc_pkg::*;
#(
  parameter int OSR   = 100,
  parameter int ORDER = 2,
  parameter int RES_W = 12,
  parameter int EST_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             mod_bit_i,
  input  logic             adapt_en_i,
  output logic [EST_W-1:0] bias_en_o,
  output logic             busy_o,
  output logic [RES_W-1:0] result_o,
  output logic             result_vld_o
);
  localparam int FS    = full_scale(OSR, ORDER);
  localparam int ACC_W = $clog2(FS + 1) + 1;
  localparam int CNT_W = $clog2(OSR);
  localparam logic signed [ACC_W-1:0] POS_ONE = ACC_W'(1);
  localparam logic signed [ACC_W-1:0] NEG_ONE = '1;

  seq_t             seq_st;
  logic [CNT_W-1:0] cnt;
  logic             conv_start;
  logic             step;
  logic             first_evt;
  logic             last_evt;
  logic [EST_W-1:0] est_next;
  logic [RES_W-1:0] res_q;
  logic             vld_q;

  logic signed [ACC_W-1:0] stage_in  [1:ORDER];
  logic signed [ACC_W-1:0] stage_sum [1:ORDER];

  iadc_seq_ctrl #(.OSR(OSR), .CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .accept_o (conv_start),
    .st_o     (seq_st),
    .cnt_o    (cnt)
  );

  assign step      = seq_st.busy;
  assign first_evt = seq_st.first;
  assign last_evt  = seq_st.last;

  assign stage_in[1] = mod_bit_i ? POS_ONE : NEG_ONE;

  for (genvar k = 1; k <= ORDER; k++) begin : g_stage
    iadc_integrator #(.W(ACC_W)) u_int (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (conv_start),
      .en_i  (step),
      .in_i  (stage_in[k]),
      .sum_o (stage_sum[k])
    );
    if (k < ORDER) begin : g_chain
      assign stage_in[k+1] = stage_sum[k];
    end
  end

  assign est_next = EST_W'(scale_clamp(int'(stage_sum[1]), int'(cnt) + 1, EST_W));

  iadc_bias_ctrl #(.EST_W(EST_W)) u_bias (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (conv_start),
    .step_i     (step),
    .mod_bit_i  (mod_bit_i),
    .adapt_en_i (adapt_en_i),
    .est_next_i (est_next),
    .bias_o     (bias_en_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= last_evt;
      if (last_evt) res_q <= RES_W'(scale_clamp(int'(stage_sum[ORDER]), FS, RES_W));
    end
  end

  assign busy_o       = seq_st.busy;
  assign result_o     = res_q;
  assign result_vld_o = vld_q;
endmodule

// File: rtl/iadc_checker.sv
module iadc_checker #(
  parameter int RES_W = 12,
  parameter int EST_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             mod_bit_i,
  input logic             adapt_en_i,
  input logic [EST_W-1:0] bias_en_o,
  input logic             busy_o,
  input logic [RES_W-1:0] result_o,
  input logic             result_vld_o,
  input logic             first_evt,
  input logic             last_evt
);
  localparam logic [EST_W-1:0] MID = EST_W'(1) << (EST_W - 1);

  // R3: a conversion is not cut short or restarted by start_i
  p_keep_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !last_evt) |=> busy_o);

  // R2: an idle start is always taken
  p_start_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o);

  // R5: valid is a single pulse that follows the end of busy
  p_vld_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld_o |=> !result_vld_o);
  p_vld_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld_o |-> $fell(busy_o));
  p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !result_vld_o |-> $stable(result_o));

  // R6/R7: first sample of a conversion uses the mid-scale estimate
  p_first_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (first_evt && adapt_en_i) |=> (bias_en_o == ($past(mod_bit_i) ? ~MID : MID)));

  // R8: adaptive scheme bypassed
  p_bypass_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !adapt_en_i |=> (bias_en_o == '1));

  // R9: full bias while idle
  p_idle_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> (bias_en_o == '1));
endmodule

bind iadc_decimator iadc_checker #(.RES_W(RES_W), .EST_W(EST_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .mod_bit_i    (mod_bit_i),
  .adapt_en_i   (adapt_en_i),
  .bias_en_o    (bias_en_o),
  .busy_o       (busy_o),
  .result_o     (result_o),
  .result_vld_o (result_vld_o),
  .first_evt    (first_evt),
  .last_evt     (last_evt)
);

// File: tb/test_iadc_decimator.sv
module test_iadc_decimator;
  localparam int CLK_PERIOD = 10;
  localparam int N = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       mod_bit_i = 1'b0;
  logic       adapt_en_i = 1'b1;
  logic [3:0] bias_en_o;
  logic       busy_o;
  logic [11:0] result_o;
  logic       result_vld_o;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  logic pat [0:N-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  iadc_decimator i_iadc_decimator (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mod_bit_i(mod_bit_i),
    .adapt_en_i(adapt_en_i), .bias_en_o(bias_en_o), .busy_o(busy_o),
    .result_o(result_o), .result_vld_o(result_vld_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int offset_code(input int s, input int span, input int mid);
    int q;
    int v;
    q = ((s < 0 ? -s : s) * mid) / span;
    v = (s < 0) ? mid - q : mid + q;
    if (v < 0) v = 0;
    if (v > 2 * mid - 1) v = 2 * mid - 1;
    return v;
  endfunction

  task automatic gen_density(input int q);
    int acc = 0;
    for (int i = 0; i < N; i++) begin
      acc += q;
      if (acc >= 16) begin acc -= 16; pat[i] = 1'b1; end
      else pat[i] = 1'b0;
    end
  endtask

  task automatic gen_lfsr(input logic [15:0] seed);
    logic [15:0] r = seed;
    for (int i = 0; i < N; i++) begin
      r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
      pat[i] = r[0];
    end
  endtask

  // amode: 0 off, 1 on, 2 toggles every 7 samples. mid_start: pulse start at sample 50.
  task automatic run_conv(input int amode, input bit mid_start, input bit gap);
    int s1 = 0;
    int s2 = 0;
    int est = 8;
    int exp_bias;
    bit a;
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    check("R2 busy after start", busy_o, 1);
    check("R9 bias at start edge", bias_en_o, 15);
    for (int c = 0; c < N; c++) begin
      a = (amode == 1) || (amode == 2 && ((c / 7) % 2 == 0));
      adapt_en_i = a;
      mod_bit_i = pat[c];
      start_i = mid_start && (c == 50);
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      if (!a) exp_bias = 15;
      else exp_bias = pat[c] ? 15 - est : est;
      check(a ? "R7 adaptive bias" : "R8 bypass bias", bias_en_o, exp_bias);
      if (c == 0 && a) check("R6 mid-scale first estimate", bias_en_o, pat[0] ? 7 : 8);
      s1 += pat[c] ? 1 : -1;
      s2 += s1;
      est = offset_code(s1, c + 1, 8);
      if (c < N - 1) begin
        check("R3 busy held", busy_o, 1);
        check("R5 no early valid", result_vld_o, 0);
      end
    end
    adapt_en_i = 1'b1;
    check("R2 busy ends after 100", busy_o, 0);
    check("R5 valid pulse", result_vld_o, 1);
    check("R4 result", result_o, offset_code(s2, 5050, 2048));
    if (gap) begin
      @(posedge clk);
      @(negedge clk);
      check("R5 valid single", result_vld_o, 0);
      check("R5 result held", result_o, offset_code(s2, 5050, 2048));
      check("R9 idle bias", bias_en_o, 15);
      check("R2 stays idle", busy_o, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy_o, 0);
    check("R1 valid", result_vld_o, 0);
    check("R1 result", result_o, 0);
    check("R1 bias", bias_en_o, 15);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle bias after reset", bias_en_o, 15);
    for (int q = 0; q <= 16; q++) begin
      gen_density(q);
      run_conv(1, 1'b0, 1'b1);
    end
    gen_lfsr(16'hACE1);
    run_conv(1, 1'b0, 1'b1);
    gen_density(5);
    run_conv(0, 1'b0, 1'b1);
    gen_density(11);
    run_conv(2, 1'b0, 1'b1);
    gen_density(3);
    run_conv(1, 1'b1, 1'b0);   // R3 stray start, then back-to-back start in valid cycle
    gen_lfsr(16'h1234);
    run_conv(1, 1'b1, 1'b1);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule